// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block translates 32-bit virtual addresses to physical addresses through a small, fully associative table of sixteen entries. Each entry covers two neighbouring 4 KB virtual pages that share one tag. The tag holds a page-pair number, an address-space identifier and a global flag. The tag feeds two halves, one for the even page and one for the odd page. Each half holds its own frame number, a 3-bit cache attribute, a valid flag and a dirty flag.

Software loads a whole entry in one cycle through an indexed write port. The lookup port is purely combinational on the registered table. It takes an address, the current identifier and a read/write flag. It returns either a physical address with its cache attribute, or exactly one fault code: miss, invalid or modified.

The block has no state machine beyond the table itself. Reset clears every entry, and the write port is the only way to change the table.

Top module: `pairtlb_xlate`

## Requirements
- R1: After reset every entry is all zero, so a lookup reports no successful translation: fault code 2 for page pair 0 with identifier 0, and fault code 1 elsewhere.
- R2: When `wr_en` is high at a rising clock edge, entry `wr_idx` takes all write fields. A lookup in the same cycle still sees the old contents. From the next cycle on, lookups see the new contents.
- R3: An entry matches when its page-pair number equals `lk_vaddr[31:13]` and either its identifier equals `lk_asid` or its global flag is 1.
- R4: If no entry matches, `lk_fault` is 1 (miss) and `lk_ok` is 0.
- R5: `lk_vaddr[12]` selects the half of the matching entry: 0 selects the even half and 1 selects the odd half.
- R6: If the selected half has its valid flag at 0, `lk_fault` is 2 (invalid).
- R7: If the selected half is valid, its dirty flag is 0 and `lk_write` is 1, `lk_fault` is 3 (modified). A read of that half succeeds.
- R8: On success `lk_ok` is 1 and `lk_fault` is 0. `lk_paddr` is the half's frame number followed by `lk_vaddr[11:0]`, and `lk_attr` is the half's cache attribute. On any fault `lk_paddr` and `lk_attr` are 0.
- R9: Only one fault is reported. Miss takes priority over invalid, and invalid takes priority over modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 4 | Entry index to load |
| wr_vpn2 | input | 19 | Page-pair number |
| wr_asid | input | 8 | Address-space identifier |
| wr_global | input | 1 | Ignore identifier when matching |
| wr_pfn_even | input | 20 | Even-half frame number |
| wr_attr_even | input | 3 | Even-half cache attribute |
| wr_valid_even | input | 1 | Even-half valid flag |
| wr_dirty_even | input | 1 | Even-half writable flag |
| wr_pfn_odd | input | 20 | Odd-half frame number |
| wr_attr_odd | input | 3 | Odd-half cache attribute |
| wr_valid_odd | input | 1 | Odd-half valid flag |
| wr_dirty_odd | input | 1 | Odd-half writable flag |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | Access is a store |
| lk_paddr | output | 32 | Translated physical address |
| lk_attr | output | 3 | Cache attribute of the translation |
| lk_ok | output | 1 | Translation succeeded |
| lk_fault | output | 2 | 0 none, 1 miss, 2 invalid, 3 modified |

## Verification
The bench builds the block with its default of sixteen entries and 8-bit identifiers. This makes every index reachable, so writes to the first, middle and last slots are all exercised. The random phase draws identifiers from a narrow set and marks about a quarter of the entries global. As a result, both identifier hits, identifier misses and global overrides occur often. Page-pair numbers are tied to each slot index, so every lookup hits at most one entry, while both halves and both access types are still covered.

// File: rtl/pairtlb_pkg.sv
package pairtlb_pkg;
    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPN2_W   = VA_W - OFF_W - 1;
    localparam int PFN_W    = 20;
    localparam int PA_W     = PFN_W + OFF_W;
    localparam int ATTR_W   = 3;
    localparam int ASID_W   = 8;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              valid;
        logic              dirty;
    } half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              global_en;
        half_t             even;
        half_t             odd;
    } entry_t;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_MISS     = 2'd1,
        FLT_INVALID  = 2'd2,
        FLT_MODIFIED = 2'd3
    } fault_e;
endpackage

// File: rtl/pairtlb_store.sv
module pairtlb_store
    import pairtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_entry,
    output entry_t           entries [NUM_ENTRIES]
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                entries[i] <= '0;
            end
        end else if (wr_en) begin
            entries[wr_idx] <= wr_entry;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (entries[$past(wr_idx)] == $past(wr_entry))); // R2
endmodule

// File: rtl/pairtlb_match.sv
module pairtlb_match
    import pairtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  entry_t                  entries [NUM_ENTRIES],
    input  logic [VPN2_W-1:0]       lk_vpn2,
    input  logic [ASID_W-1:0]       lk_asid,
    output logic [NUM_ENTRIES-1:0]  match_vec
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic tag_eq;
        logic id_ok;
        assign tag_eq = (entries[g].vpn2 == lk_vpn2);
        assign id_ok  = entries[g].global_en || (entries[g].asid == lk_asid);
        assign match_vec[g] = tag_eq && id_ok;
    end
endmodule

// File: rtl/pairtlb_resolve.sv
module pairtlb_resolve
    import pairtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  entry_t                  entries [NUM_ENTRIES],
    input  logic [NUM_ENTRIES-1:0]  match_vec,
    input  logic                    lk_odd,
    input  logic [OFF_W-1:0]        lk_offset,
    input  logic                    lk_write,
    output logic [PA_W-1:0]         lk_paddr,
    output logic [ATTR_W-1:0]       lk_attr,
    output logic                    lk_ok,
    output fault_e                  lk_fault
);
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    half_t            sel_half;

    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign sel_half = lk_odd ? entries[hit_idx].odd : entries[hit_idx].even;

    always_comb begin
        if (!any_hit) begin
            lk_fault = FLT_MISS;
        end else if (!sel_half.valid) begin
            lk_fault = FLT_INVALID;
        end else if (lk_write && !sel_half.dirty) begin
            lk_fault = FLT_MODIFIED;
        end else begin
            lk_fault = FLT_NONE;
        end
    end

    always_comb begin
        lk_ok    = (lk_fault == FLT_NONE);
        lk_paddr = lk_ok ? {sel_half.pfn, lk_offset} : '0;
        lk_attr  = lk_ok ? sel_half.attr : '0;
    end

    AST_MODIFIED_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault == FLT_MODIFIED) |-> lk_write); // R7
    AST_INVALID_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault == FLT_INVALID) |-> (match_vec != '0)); // R9
endmodule

// File: rtl/pairtlb_xlate.sv
module pairtlb_xlate
    import pairtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic [ATTR_W-1:0] wr_attr_even,
    input  logic              wr_valid_even,
    input  logic              wr_dirty_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic [ATTR_W-1:0] wr_attr_odd,
    input  logic              wr_valid_odd,
    input  logic              wr_dirty_odd,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              lk_ok,
    output logic [1:0]        lk_fault
);
    entry_t                 wr_entry;
    entry_t                 table_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match_vec;
    fault_e                 fault_code;

    always_comb begin
        wr_entry.vpn2       = wr_vpn2;
        wr_entry.asid       = wr_asid;
        wr_entry.global_en  = wr_global;
        wr_entry.even.pfn   = wr_pfn_even;
        wr_entry.even.attr  = wr_attr_even;
        wr_entry.even.valid = wr_valid_even;
        wr_entry.even.dirty = wr_dirty_even;
        wr_entry.odd.pfn    = wr_pfn_odd;
        wr_entry.odd.attr   = wr_attr_odd;
        wr_entry.odd.valid  = wr_valid_odd;
        wr_entry.odd.dirty  = wr_dirty_odd;
    end

    pairtlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .entries  (table_q)
    );

    pairtlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .entries   (table_q),
        .lk_vpn2   (lk_vaddr[VA_W-1 -: VPN2_W]),
        .lk_asid   (lk_asid),
        .match_vec (match_vec)
    );

    pairtlb_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .entries   (table_q),
        .match_vec (match_vec),
        .lk_odd    (lk_vaddr[OFF_W]),
        .lk_offset (lk_vaddr[OFF_W-1:0]),
        .lk_write  (lk_write),
        .lk_paddr  (lk_paddr),
        .lk_attr   (lk_attr),
        .lk_ok     (lk_ok),
        .lk_fault  (fault_code)
    );

    assign lk_fault = fault_code;

    AST_MISS_WITHOUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec == '0) |-> (lk_fault == 2'd1)); // R4
    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ok |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])); // R8
    AST_FAULT_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault != 2'd0) |-> (lk_paddr == '0 && lk_attr == '0 && !lk_ok)); // R8
endmodule

// File: tb/sim_pairtlb_xlate.sv
module sim_pairtlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn_even = '0;
    logic [2:0]  wr_attr_even = '0;
    logic        wr_valid_even = 1'b0;
    logic        wr_dirty_even = 1'b0;
    logic [19:0] wr_pfn_odd = '0;
    logic [2:0]  wr_attr_odd = '0;
    logic        wr_valid_odd = 1'b0;
    logic        wr_dirty_odd = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_paddr;
    logic [2:0]  lk_attr;
    logic        lk_ok;
    logic [1:0]  lk_fault;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [18:0] m_vpn2 [16];
    logic [7:0]  m_asid [16];
    logic        m_g    [16];
    logic [19:0] m_pfn  [16][2];
    logic [2:0]  m_attr [16][2];
    logic        m_v    [16][2];
    logic        m_d    [16][2];

    always #5 clk = ~clk;

    pairtlb_xlate u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_pfn_even(wr_pfn_even), .wr_attr_even(wr_attr_even),
        .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_attr_odd(wr_attr_odd),
        .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
        .lk_paddr(lk_paddr), .lk_attr(lk_attr), .lk_ok(lk_ok), .lk_fault(lk_fault)
    );

    task automatic check_now(input string tag);
        int   hit = -1;
        int   h;
        logic [1:0]  e_fault;
        logic [31:0] e_pa = '0;
        logic [2:0]  e_attr = '0;
        string t;
        for (int i = 0; i < 16; i++) begin
            if (hit < 0 && m_vpn2[i] == lk_vaddr[31:13] && (m_g[i] || m_asid[i] == lk_asid))
                hit = i;
        end
        h = int'(lk_vaddr[12]);
        if (hit < 0) e_fault = 2'd1;
        else if (!m_v[hit][h]) e_fault = 2'd2;
        else if (lk_write && !m_d[hit][h]) e_fault = 2'd3;
        else begin
            e_fault = 2'd0;
            e_pa = {m_pfn[hit][h], lk_vaddr[11:0]};
            e_attr = m_attr[hit][h];
        end
        t = tag;
        if (t == "") begin
            case (e_fault)
                2'd1: t = "R4";
                2'd2: t = "R6";
                2'd3: t = "R7";
                default: t = "R8";
            endcase
        end
        total++;
        if (lk_fault !== e_fault || lk_ok !== (e_fault == 2'd0) ||
            lk_paddr !== e_pa || lk_attr !== e_attr) begin
            bad++;
            $display("FAIL %s: fault=%0d ok=%0d pa=%h attr=%0d expected fault=%0d ok=%0d pa=%h attr=%0d",
                     t, lk_fault, lk_ok, lk_paddr, lk_attr, e_fault, (e_fault == 2'd0), e_pa, e_attr);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (wr_en) begin
            m_vpn2[wr_idx] = wr_vpn2;
            m_asid[wr_idx] = wr_asid;
            m_g[wr_idx] = wr_global;
            m_pfn[wr_idx][0] = wr_pfn_even; m_attr[wr_idx][0] = wr_attr_even;
            m_v[wr_idx][0] = wr_valid_even; m_d[wr_idx][0] = wr_dirty_even;
            m_pfn[wr_idx][1] = wr_pfn_odd;  m_attr[wr_idx][1] = wr_attr_odd;
            m_v[wr_idx][1] = wr_valid_odd;  m_d[wr_idx][1] = wr_dirty_odd;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int idx, input logic [18:0] vpn2, input logic [7:0] asid, input logic g,
                        input logic [19:0] pe, input logic [2:0] ae, input logic ve, input logic de,
                        input logic [19:0] po, input logic [2:0] ao, input logic vo, input logic d_o);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn2 = vpn2; wr_asid = asid; wr_global = g;
        wr_pfn_even = pe; wr_attr_even = ae; wr_valid_even = ve; wr_dirty_even = de;
        wr_pfn_odd = po; wr_attr_odd = ao; wr_valid_odd = vo; wr_dirty_odd = d_o;
    endtask

    task automatic look(input logic [18:0] vpn2, input logic odd, input logic [11:0] off,
                        input logic [7:0] asid, input logic wr, input string tag);
        lk_vaddr = {vpn2, odd, off}; lk_asid = asid; lk_write = wr;
        #1;
        check_now(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_vpn2[i] = '0; m_asid[i] = '0; m_g[i] = 1'b0;
            for (int h = 0; h < 2; h++) begin
                m_pfn[i][h] = '0; m_attr[i][h] = '0; m_v[i][h] = 1'b0; m_d[i][h] = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        look(19'h0, 1'b0, 12'h000, 8'h00, 1'b0, "R1");
        look(19'h00042, 1'b1, 12'h123, 8'h07, 1'b0, "R1");

        load(2, 19'h12345, 8'h05, 1'b0, 20'hAAAAA, 3'd3, 1'b1, 1'b1, 20'h55555, 3'd5, 1'b1, 1'b0);
        look(19'h12345, 1'b0, 12'hABC, 8'h05, 1'b0, "R2");
        tick();
        look(19'h12345, 1'b0, 12'hABC, 8'h05, 1'b0, "R2");
        look(19'h12345, 1'b1, 12'hABC, 8'h05, 1'b0, "R5");
        look(19'h12345, 1'b1, 12'h001, 8'h05, 1'b1, "R7");
        look(19'h12345, 1'b0, 12'hFFF, 8'h05, 1'b1, "R8");
        look(19'h12345, 1'b0, 12'hABC, 8'h06, 1'b0, "R3");

        load(7, 19'h00777, 8'h00, 1'b1, 20'h11111, 3'd2, 1'b0, 1'b0, 20'h22222, 3'd6, 1'b1, 1'b1);
        tick();
        look(19'h00777, 1'b0, 12'h010, 8'h3C, 1'b1, "R9");
        look(19'h00777, 1'b0, 12'h010, 8'h3C, 1'b0, "R6");
        look(19'h00777, 1'b1, 12'h020, 8'h99, 1'b1, "R3");
        look(19'h00778, 1'b1, 12'h020, 8'h99, 1'b0, "R4");

        load(15, 19'h7FFFF, 8'hFF, 1'b0, 20'hFFFFF, 3'd7, 1'b1, 1'b1, 20'h00001, 3'd1, 1'b0, 1'b1);
        tick();
        look(19'h7FFFF, 1'b0, 12'hFFF, 8'hFF, 1'b1, "R8");
        look(19'h7FFFF, 1'b1, 12'hFFF, 8'hFF, 1'b1, "R6");

        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 3 == 0) begin
                int idx;
                idx = int'($urandom % 16);
                load(idx, 19'(19'h100 | ((($urandom % 4)) << 4) | idx),
                     8'(1 + $urandom % 3), ($urandom % 4) == 0,
                     20'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                     20'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
            end
            look(19'(19'h100 | ((($urandom % 4)) << 4) | ($urandom % 16)), 1'($urandom),
                 12'($urandom), 8'(1 + $urandom % 3), 1'($urandom), "");
            tick();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule